// File: doc/BRIEF.md
# Card Slot Power State Controller

This block sequences the three supply rails of a hot-plug card slot: a primary 3.3 V rail, a primary 1.5 V rail and an auxiliary 3.3 V rail. It takes two active-low card-detect pins, one for a PCI Express card and one for a USB card. It also takes a system-status pin that tells an active system from one in standby. From these it selects one of three power states: everything off, auxiliary-only standby, or fully powered. It drives a switch enable and a discharge control for every rail.

Protection flags from the supply comparators override the selected state. These are a lockout on the auxiliary input, a lockout on the primary inputs, and a thermal fault. On a thermal fault every rail is left floating, and a dedicated output reports that condition. Every input passes through a two-flop synchronizer. The card-detect result must hold for a programmable number of cycles before the controller accepts it, which filters out contact bounce during insertion.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: A card is present when `pcie_det_n` is 0, or `usb_det_n` is 0, or both are 0. With both pins at 1 there is no card.
- R2: With no card, `en_p33`, `en_p15` and `en_aux` are 0 whatever the level of `sys_active`.
- R3: With a card present and `sys_active` at 1 and no protection flag, all three enables are 1 and all three discharge outputs are 0.
- R4: With a card present and `sys_active` at 0, only `en_aux` is 1. `dis_p33` and `dis_p15` are 1 and `dis_aux` is 0.
- R5: Removing the card turns every rail off, whether the slot was in standby or fully powered.
- R6: While `aux_lockout` is 1, all three enables are 0 and all three discharge outputs are 1.
- R7: While `prim_lockout` is 1, both primary rails are off and discharging. The auxiliary rail still follows the card and system state.
- R8: While `therm_fault` is 1, every enable and every discharge output is 0 and `rails_hiz` is 1.
- R9: Whenever no thermal fault is present, the discharge output of each rail is the inverse of that rail's enable.
- R10: A change in card presence is taken only after the synchronized detect result has differed from the accepted one for `DEBOUNCE_CYCLES` consecutive cycles. A shorter excursion leaves the outputs unchanged.
- R11: During and after reset, before any card is accepted, all enables are 0, all discharges are 1 and `rails_hiz` is 0.
- R12: Toggling `sys_active` with a card present switches only the primary rails. `en_aux` stays at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcie_det_n | input | 1 | PCI Express card detect, active low |
| usb_det_n | input | 1 | USB card detect, active low |
| sys_active | input | 1 | 1 = system active, 0 = standby |
| aux_lockout | input | 1 | Auxiliary input supply below threshold |
| prim_lockout | input | 1 | Primary input supplies below threshold |
| therm_fault | input | 1 | Thermal shutdown flag |
| en_p33 | output | 1 | Primary 3.3 V switch enable |
| en_p15 | output | 1 | Primary 1.5 V switch enable |
| en_aux | output | 1 | Auxiliary 3.3 V switch enable |
| dis_p33 | output | 1 | Primary 3.3 V discharge enable |
| dis_p15 | output | 1 | Primary 1.5 V discharge enable |
| dis_aux | output | 1 | Auxiliary discharge enable |
| rails_hiz | output | 1 | All rails floating (thermal shutdown) |

## Verification
The bench attacks the debounce edge. An excursion one cycle shorter than the window must not cause even a single-cycle dip in the auxiliary enable, which a counter that is off by one would allow. An excursion of exactly the window length must be accepted. The bench also checks that only one detect pin need be low: a controller that required both pins would keep a USB-only card unpowered. Finally, it checks that a thermal fault floats the discharge paths rather than engaging them, and that a primary lockout leaves the auxiliary rail on; a design that merged the two lockouts would drop the auxiliary rail.

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl #(
  parameter int unsigned DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcie_det_n,
  input  logic usb_det_n,
  input  logic sys_active,
  input  logic aux_lockout,
  input  logic prim_lockout,
  input  logic therm_fault,
  output logic en_p33,
  output logic en_p15,
  output logic en_aux,
  output logic dis_p33,
  output logic dis_p15,
  output logic dis_aux,
  output logic rails_hiz
);

  localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);
  localparam logic [5:0] SYNC_RST = 6'b110000;

  typedef enum logic [1:0] {ST_OFF, ST_STBY, ST_FULL} st_t;

  // bit order: pcie_n, usb_n, sys, aux_lk, prim_lk, therm
  logic [5:0] s1, s2;
  logic [CW-1:0] cnt;
  logic card_db;
  logic card_raw;
  logic live;
  st_t  state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= {pcie_det_n, usb_det_n, sys_active, aux_lockout, prim_lockout, therm_fault};
      s2 <= s1;
    end
  end

  assign card_raw = ~(s2[5] & s2[4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      card_db <= 1'b0;
    end else if (card_raw == card_db) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt     <= '0;
      card_db <= card_raw;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_OFF;
    else if (!card_db) state <= ST_OFF;
    else if (s2[3])    state <= ST_FULL;
    else               state <= ST_STBY;
  end

  assign rails_hiz = s2[0];
  assign live      = !s2[0] && !s2[2];
  assign en_aux    = live && (state != ST_OFF);
  assign en_p33    = live && !s2[1] && (state == ST_FULL);
  assign en_p15    = live && !s2[1] && (state == ST_FULL);
  assign dis_aux   = !rails_hiz && !en_aux;
  assign dis_p33   = !rails_hiz && !en_p33;
  assign dis_p15   = !rails_hiz && !en_p15;

  a_r8_thermal_float: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_fault ##1 therm_fault) |=> (rails_hiz && !en_aux && !en_p33 && !en_p15
                                       && !dis_aux && !dis_p33 && !dis_p15));

  a_r6_aux_lock_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_lockout ##1 aux_lockout) |=> (!en_aux && !en_p33 && !en_p15));

  a_r7_prim_lock_off: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_lockout ##1 prim_lockout) |=> (!en_p33 && !en_p15));

  a_r9_primary_needs_aux: assert property (@(posedge clk) disable iff (!rst_n)
    (en_p33 || en_p15) |-> en_aux);

  a_r4_standby_prim_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY) |-> (!en_p33 && !en_p15));

  a_r5_no_card_off: assert property (@(posedge clk) disable iff (!rst_n)
    !card_db |=> !en_aux);

  a_r10_hold_until_window: assert property (@(posedge clk) disable iff (!rst_n)
    (card_raw != card_db && cnt != CNT_LAST) |=> $stable(card_db));

endmodule

// File: tb/test_slot_pwr_ctrl.sv
module test_slot_pwr_ctrl;
  localparam int unsigned DEB = 4;
  localparam int unsigned SETTLE = DEB + 8;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pcie_det_n = 1'b1, usb_det_n = 1'b1, sys_active = 1'b0;
  logic aux_lockout = 1'b0, prim_lockout = 1'b0, therm_fault = 1'b0;
  logic en_p33, en_p15, en_aux, dis_p33, dis_p15, dis_aux, rails_hiz;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  bit armed = 0;
  bit dropped = 0;

  always #2.5 clk = ~clk;

  slot_pwr_ctrl #(.DEBOUNCE_CYCLES(DEB)) i_slot_pwr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pcie_det_n(pcie_det_n), .usb_det_n(usb_det_n), .sys_active(sys_active),
    .aux_lockout(aux_lockout), .prim_lockout(prim_lockout), .therm_fault(therm_fault),
    .en_p33(en_p33), .en_p15(en_p15), .en_aux(en_aux),
    .dis_p33(dis_p33), .dis_p15(dis_p15), .dis_aux(dis_aux), .rails_hiz(rails_hiz)
  );

  logic [6:0] outs;
  assign outs = {en_p33, en_p15, en_aux, dis_p33, dis_p15, dis_aux, rails_hiz};

  // [12:7] pcie_n usb_n sys aux_lk prim_lk therm ; [6:0] e33 e15 eaux d33 d15 daux hiz
  localparam logic [12:0] VEC [NV] = '{
    13'b110000_0001110,
    13'b111000_0001110,
    13'b011000_1110000,
    13'b010000_0011100,
    13'b110000_0001110,
    13'b101000_1110000,
    13'b111000_0001110,
    13'b001000_1110000,
    13'b001100_0001110,
    13'b001010_0011100,
    13'b000010_0011100,
    13'b001001_0000001,
    13'b111001_0000001,
    13'b001000_1110000
  };

  function automatic string tag(input int i);
    case (i)
      0, 1:  return "R2";
      2:     return "R3/R1";
      3:     return "R4";
      4:     return "R5 from standby";
      5:     return "R1 usb only";
      6:     return "R5 from full";
      7:     return "R3";
      8:     return "R6";
      9:     return "R7";
      10:    return "R7 in standby";
      11, 12: return "R8";
      default: return "R9 recovery";
    endcase
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  always @(negedge clk) if (armed && !en_aux) dropped = 1;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 in reset", outs, 7'b0001110);
    rst_n = 1'b1;
    settle();
    chk("R11 after reset", outs, 7'b0001110);

    for (int i = 0; i < NV; i++) begin
      {pcie_det_n, usb_det_n, sys_active, aux_lockout, prim_lockout, therm_fault} = VEC[i][12:7];
      settle();
      chk(tag(i), outs, VEC[i][6:0]);
    end

    // R10: excursion one cycle short of the window is ignored
    dropped = 0; armed = 1;
    pcie_det_n = 1'b1; usb_det_n = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    pcie_det_n = 1'b0; usb_det_n = 1'b0;
    repeat (3 * DEB + 8) @(negedge clk);
    armed = 0;
    chk("R10 short excursion no dip", {6'b0, dropped}, 7'b0);
    chk("R10 short excursion outputs", outs, 7'b1110000);

    // R10: excursion of exactly the window is accepted
    dropped = 0; armed = 1;
    pcie_det_n = 1'b1; usb_det_n = 1'b1;
    repeat (DEB) @(negedge clk);
    pcie_det_n = 1'b0; usb_det_n = 1'b0;
    repeat (3 * DEB + 8) @(negedge clk);
    armed = 0;
    chk("R10 full-window excursion taken", {6'b0, dropped}, 7'b1);
    chk("R10 re-powered after return", outs, 7'b1110000);

    // R12: system toggles keep aux on
    dropped = 0; armed = 1;
    sys_active = 1'b0;
    settle();
    chk("R12 standby primaries off", outs, 7'b0011100);
    sys_active = 1'b1;
    settle();
    chk("R12 active again", outs, 7'b1110000);
    armed = 0;
    chk("R12 aux never dropped", {6'b0, dropped}, 7'b0);

    // R9/R6: aux lockout from standby discharges all
    sys_active = 1'b0; aux_lockout = 1'b1;
    settle();
    chk("R6 lockout from standby", outs, 7'b0001110);
    aux_lockout = 1'b0;
    settle();
    chk("R9 standby restored", outs, 7'b0011100);

    // R11: reset mid-operation returns to all-off
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset while powered", outs, 7'b0001110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 held off within window", outs, 7'b0001110);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule